// File: doc/BRIEF.md
# Bit-Serial Constant-Coefficient Multiplier

This block multiplies a serial two's-complement multiplicand by one fixed integer coefficient that is chosen when the design is elaborated. The multiplicand arrives one bit per clock, least significant bit first. A framing input is high together with the first bit of each word. The product leaves on a single output line, also least significant bit first. Each product bit appears exactly one clock after the multiplicand bit of the same weight.

Internally the coefficient is reduced to its shortest binary form. A positive value uses its plain magnitude bits with no sign bit, so 11 becomes 1011. A negative value uses its shortest two's-complement form, so -5 becomes 1011. One single-bit cell is built per bit of that form. The multiplicand enters at the most significant cell, and partial results ripple down to the least significant cell, whose register drives the output.

- Below the top bit, a 1 becomes a carry-holding serial adder and a 0 becomes a plain delay that clears at a word boundary.
- The top bit becomes a pass-through register for a positive coefficient, or a serial negation cell for a negative one.

The word length is set by the spacing of the framing pulses. The product is the low bits of the full product, so the caller sign-extends the multiplicand far enough that the kept bits hold the whole result.

Top module: `bsmul_const`

## Requirements
- R1: For a positive coefficient C and a W-bit word x (word_start high with bit 0 of x, followed by bits 1..W-1 on consecutive clocks), the W output bits taken one clock after each input bit equal the low W bits of C*x, with x read as signed.
- R2: For a negative coefficient, the W output bits equal the low W bits of C*x. The top cell negates serially: it passes bits up to and including the first 1, then inverts the rest.
- R3: Product bit j is on p_bit in the clock cycle after multiplicand bit j was sampled. In particular, the first output bit of a word equals x bit 0 AND coefficient bit 0.
- R4: Words sent back to back, with no gap, each give a product independent of the word before. No carry or partial sum crosses a word_start.
- R5: While rst is high, and in the cycle after it, p_bit is 0.
- R6: Extra clocks with word_start low after the last bit of a word, whatever x_bit carries during them, do not change the product of the next word.
- R7: With a coefficient of 0, p_bit stays 0 for every input.
- R8: Products wider than W bits are truncated to their low W bits, for example 127*127 gives 0x01 and -128*2 gives 0x00 when W is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| x_bit | input | 1 | Serial multiplicand, LSB first |
| word_start | input | 1 | High with bit 0 of each word |
| p_bit | output | 1 | Registered serial product, LSB first |

## Verification
The main hazard is state crossing a word boundary. The bench sends words back to back, including all-ones followed by a small value. An adder that keeps its carry, or a delay cell that does not clear, would put a stray 1 into the low bits of the second product. A negation cell whose "seen a one" flag is not cleared would invert the whole next word, and the negative coefficients, including -1 and -128, expose that. Padding clocks filled with ones between words check that only word_start, and not a bit count, frames the result. Products whose upper bits fall off check that truncation keeps the low half.

// File: rtl/bsmul_pkg.sv
package bsmul_pkg;

  typedef enum logic [1:0] {
    CELL_ZERO = 2'd0,
    CELL_ADD  = 2'd1,
    CELL_PASS = 2'd2,
    CELL_NEG  = 2'd3
  } cell_kind_e;

  // Shortest form: magnitude bits for positive values, two's complement for negative.
  function automatic int coef_len(input int c);
    int n;
    n = 1;
    if (c > 0) begin
      for (int k = 32; k >= 1; k--)
        if (longint'(c) < (longint'(1) <<< k)) n = k;
    end else if (c < 0) begin
      for (int k = 32; k >= 1; k--)
        if (longint'(c) >= -(longint'(1) <<< (k - 1))) n = k;
    end
    return n;
  endfunction

  function automatic cell_kind_e pick_cell(input int c, input int pos, input int len);
    logic b;
    b = 1'((c >>> pos) & 1);
    if (pos == len - 1) begin
      if (c < 0)      return CELL_NEG;
      else if (c > 0) return CELL_PASS;
      else            return CELL_ZERO;
    end
    return b ? CELL_ADD : CELL_ZERO;
  endfunction

endpackage

// File: rtl/bsmul_add_cell.sv
module bsmul_add_cell (
  input  logic clk,
  input  logic rst,
  input  logic st,
  input  logic x,
  input  logic pin,
  output logic q
);
  logic cy;
  logic pin_g, cy_g;

  assign pin_g = st ? 1'b0 : pin;
  assign cy_g  = st ? 1'b0 : cy;

  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= 1'b0;
      cy <= 1'b0;
    end else begin
      q  <= x ^ pin_g ^ cy_g;
      cy <= (x & pin_g) | (x & cy_g) | (pin_g & cy_g);
    end
  end

  // R4: with no live addend at a word start, no carry may survive into the word
  assert_carry_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (!x && (st || !pin)) |=> !cy);
endmodule

// File: rtl/bsmul_zero_cell.sv
module bsmul_zero_cell (
  input  logic clk,
  input  logic rst,
  input  logic st,
  input  logic pin,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (st) q <= 1'b0;
    else         q <= pin;
  end
endmodule

// File: rtl/bsmul_msb_cell.sv
module bsmul_msb_cell #(
  parameter bit NEG = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic st,
  input  logic x,
  output logic q
);
  generate
    if (NEG) begin : g_neg
      logic seen;
      always_ff @(posedge clk) begin
        if (rst) begin
          q    <= 1'b0;
          seen <= 1'b0;
        end else begin
          q    <= (!st && seen) ? ~x : x;
          seen <= st ? x : (seen | x);
        end
      end
      // R2: the first bit of every word leaves the negation cell unchanged
      assert_neg_first_bit_R2: assert property (@(posedge clk) disable iff (rst)
        st |=> (q == $past(x)));
    end else begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= x;
      end
    end
  endgenerate
endmodule

// File: rtl/bsmul_const.sv
module bsmul_const #(
  parameter int COEF = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic x_bit,
  input  logic word_start,
  output logic p_bit
);
  import bsmul_pkg::*;

  localparam int   NCELL = coef_len(COEF);
  localparam logic C_LSB = 1'((COEF >>> 0) & 1);

  logic [NCELL-1:0] chain;

  generate
    for (genvar i = 0; i < NCELL; i++) begin : g_cell
      localparam cell_kind_e KIND = pick_cell(COEF, i, NCELL);
      if (i == NCELL - 1) begin : g_top
        if (KIND == CELL_NEG) begin : g_n
          bsmul_msb_cell #(.NEG(1'b1)) u_cell (
            .clk(clk), .rst(rst), .st(word_start), .x(x_bit), .q(chain[i]));
        end else if (KIND == CELL_PASS) begin : g_p
          bsmul_msb_cell #(.NEG(1'b0)) u_cell (
            .clk(clk), .rst(rst), .st(word_start), .x(x_bit), .q(chain[i]));
        end else begin : g_z
          bsmul_zero_cell u_cell (
            .clk(clk), .rst(rst), .st(word_start), .pin(1'b0), .q(chain[i]));
        end
      end else begin : g_low
        if (KIND == CELL_ADD) begin : g_a
          bsmul_add_cell u_cell (
            .clk(clk), .rst(rst), .st(word_start), .x(x_bit),
            .pin(chain[i+1]), .q(chain[i]));
        end else begin : g_z
          bsmul_zero_cell u_cell (
            .clk(clk), .rst(rst), .st(word_start), .pin(chain[i+1]), .q(chain[i]));
        end
      end
    end
  endgenerate

  assign p_bit = chain[0];

  // R3: first product bit of a word is bit 0 of the multiplicand gated by coefficient bit 0
  assert_first_bit_R3: assert property (@(posedge clk) disable iff (rst)
    word_start |=> (p_bit == ($past(x_bit) & C_LSB)));

  // R5: output is quiet while reset is applied and in the cycle after
  assert_reset_quiet_R5: assert property (@(posedge clk)
    rst |=> !p_bit);

  generate
    if (COEF == 0) begin : g_zero_chk
      // R7: zero coefficient never produces a one
      assert_zero_coef_R7: assert property (@(posedge clk) disable iff (rst)
        !p_bit);
    end
  endgenerate
endmodule

// File: tb/test_bsmul_const.sv
module test_bsmul_const;
  localparam int W  = 8;
  localparam int NC = 8;
  localparam int COEFS [NC] = '{11, -5, 1, -1, 0, 6, -128, 127};
  localparam int NV = 12;
  localparam int       VK [NV] = '{0, 0, 1, 1, 2, 3, 3, 4, 5, 6, 6, 7};
  localparam logic [7:0] VX [NV] = '{8'h03, 8'hF5, 8'h07, 8'hFA, 8'hA5, 8'h01,
                                     8'h80, 8'hFF, 8'h15, 8'h01, 8'h02, 8'h7F};
  localparam logic [7:0] VP [NV] = '{8'h21, 8'h87, 8'hDD, 8'h1E, 8'hA5, 8'hFF,
                                     8'h80, 8'h00, 8'h7E, 8'h80, 8'h00, 8'h01};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x_in = 1'b0;
  logic ws = 1'b0;
  logic pb [NC];

  int checks = 0;
  int errors = 0;
  int pend = -1;
  logic [W-1:0] cap  [NC];
  logic [W-1:0] done [NC];
  logic [W-1:0] sent [$];
  string vtag [NV];

  always #5 clk = ~clk;

  generate
    for (genvar k = 0; k < NC; k++) begin : g_dut
      bsmul_const #(.COEF(COEFS[k])) i_bsmul_const (
        .clk(clk), .rst(rst), .x_bit(x_in), .word_start(ws), .p_bit(pb[k]));
    end
  endgenerate

  task automatic check(input bit ok, input string tag, input int act, input int exp,
                       input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_prod(input int c, input logic [W-1:0] x);
    int p;
    p = c * int'($signed(x));
    return p[W-1:0];
  endfunction

  task automatic finish_word();
    logic [W-1:0] xw;
    string tag;
    xw = sent.pop_front();
    for (int k = 0; k < NC; k++) begin
      done[k] = cap[k];
      tag = (COEFS[k] > 0) ? "R1" : (COEFS[k] < 0) ? "R2" : "R7";
      check(done[k] == ref_prod(COEFS[k], xw), tag, done[k], ref_prod(COEFS[k], xw),
            $sformatf("coef %0d x 0x%0h", COEFS[k], xw));
    end
  endtask

  task automatic tick(input logic xb, input logic st, input int b);
    @(negedge clk);
    if (pend >= 0) begin
      for (int k = 0; k < NC; k++) cap[k][pend] = pb[k];
      if (pend == W - 1) finish_word();
    end
    x_in = xb;
    ws   = st;
    pend = b;
  endtask

  task automatic send(input logic [W-1:0] x);
    sent.push_back(x);
    for (int b = 0; b < W; b++) tick(x[b], b == 0, b);
  endtask

  task automatic idle(input logic xb);
    tick(xb, 1'b0, -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vtag = '{"R1", "R1", "R2", "R2", "R1", "R2", "R8", "R7", "R1", "R2", "R8", "R8"};

    // R5: quiet during reset even with busy inputs, and just after release
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      x_in = c[0];
      ws   = c[1];
      for (int k = 0; k < NC; k++)
        check(pb[k] == 1'b0, "R5", pb[k], 0, "during reset");
    end
    @(negedge clk);
    rst = 1'b0; x_in = 1'b0; ws = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NC; k++)
      check(pb[k] == 1'b0, "R5", pb[k], 0, "after reset");

    // Vector table
    for (int v = 0; v < NV; v++) begin
      send(VX[v]);
      idle(1'b0);
      check(done[VK[v]] == VP[v], vtag[v], done[VK[v]], VP[v],
            $sformatf("table entry %0d", v));
    end

    // R3: product bit 0 sampled one clock after multiplicand bit 0
    sent.push_back(8'h01);
    tick(1'b1, 1'b1, 0);
    tick(1'b0, 1'b0, 1);
    check(cap[0][0] == 1'b1, "R3", cap[0][0], 1, "coef 11 first bit");
    check(cap[5][0] == 1'b0, "R3", cap[5][0], 0, "coef 6 first bit");
    check(cap[3][0] == 1'b1, "R3", cap[3][0], 1, "coef -1 first bit");
    for (int b = 2; b < W; b++) tick(1'b0, 1'b0, b);
    idle(1'b0);

    // R4: back-to-back, all-ones then one
    send(8'hFF);
    send(8'h01);
    idle(1'b0);
    check(done[0] == 8'h0B, "R4", done[0], 8'h0B, "coef 11 after 0xFF");
    check(done[1] == 8'hFB, "R4", done[1], 8'hFB, "coef -5 after 0xFF");
    check(done[3] == 8'hFF, "R4", done[3], 8'hFF, "coef -1 after 0xFF");

    // R6: padding clocks full of ones between words
    send(8'hFF);
    idle(1'b1);
    idle(1'b1);
    idle(1'b1);
    send(8'h03);
    idle(1'b0);
    check(done[0] == 8'h21, "R6", done[0], 8'h21, "coef 11 after padding");
    check(done[1] == 8'hF1, "R6", done[1], 8'hF1, "coef -5 after padding");

    // Full sweep, back to back (R1, R2, R7, R8 via per-word checks)
    for (int v = 0; v < 256; v++) send(8'(v));
    idle(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule